// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block joins two 8-bit buses, called A and B, and moves data between them in either direction. Each direction has a storage register that captures its own source bus on the rising edge of its own clock. The two clocks are independent. The word sent to the far bus comes from one of two sources, picked per direction: the live input of the source bus, or the word held in that direction's register. The select path is built so that a change of source does not produce a wrong value in between.

An active-low output enable and a direction select decide which bus, if either, is driven. With the enable low, the direction select picks the driven side, and the other side acts as the input. With the enable high, both sides are isolated. Both registers go on capturing on their own clock edges while the block is isolated. Each bus is split into an input vector, an output vector and a drive flag, so the block can sit inside a synchronous design. A build parameter chooses a true or an inverting data path.

Top module: `xcvr_reg_bidir`

## Requirements
- R1: On each rising edge of `clk_ab` with `rst_n` high, the A-side register loads `a_in`. Edges of `clk_ba` leave it unchanged.
- R2: On each rising edge of `clk_ba` with `rst_n` high, the B-side register loads `b_in`. Edges of `clk_ab` leave it unchanged.
- R3: While `rst_n` and `dir` are high and `oe_n` is low, `b_oe`=1 and `a_oe`=0. While `rst_n` is high and `oe_n` and `dir` are both low, `a_oe`=1 and `b_oe`=0.
- R4: While `oe_n` is high, `a_oe`=0 and `b_oe`=0, and both registers still capture on their clock edges.
- R5: With `sel_ab`=0, `b_out` follows `a_in` combinationally. With `sel_ab`=1, `b_out` shows the A-side register.
- R6: With `sel_ba`=0, `a_out` follows `b_in` combinationally. With `sel_ba`=1, `a_out` shows the B-side register.
- R7: `a_oe` and `b_oe` are never both 1.
- R8: With `INVERT`=1, `a_out` and `b_out` are the bitwise complement of the word that R5 and R6 select. With `INVERT`=0, they equal that word.
- R9: A rising clock edge with `rst_n` low clears that clock's register to 0. While `rst_n` is low, both drive flags are 0.
- R10: On the stored path, the output keeps its value when the live input changes, until the next capturing edge.
- R11: When the live input equals the stored word, toggling the source select leaves the output unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ab | input | 1 | Capture clock of the A-side register |
| clk_ba | input | 1 | Capture clock of the B-side register |
| rst_n | input | 1 | Synchronous active-low reset, sampled by each clock |
| oe_n | input | 1 | Active-low output enable; high isolates both buses |
| dir | input | 1 | 1 drives B from the A path, 0 drives A from the B path |
| sel_ab | input | 1 | A-to-B source: 0 live `a_in`, 1 stored A word |
| sel_ba | input | 1 | B-to-A source: 0 live `b_in`, 1 stored B word |
| a_in | input | 8 | Value currently on bus A |
| a_out | output | 8 | Word offered to bus A |
| a_oe | output | 1 | Bus A is driven by the block |
| b_in | input | 8 | Value currently on bus B |
| b_out | output | 8 | Word offered to bus B |
| b_oe | output | 1 | Bus B is driven by the block |

## Verification
The assertions are sampled on the edges of the two capture clocks. They assume that `a_in`, `b_in` and the selects are steady around those edges and that the clocks never rise at the same instant. The stimulus changes inputs only while both clocks are low and pulses one clock at a time. The random part walks through every combination of enable, direction and both selects, and directed cases cover reset, capture while isolated, holding of the stored path and select toggling with equal data.

// File: rtl/xcvr_pkg.sv
// Package: shared constants and types for the registered transceiver.
package xcvr_pkg;
    // Width of one bus word.
    localparam int unsigned XCVR_W = 8;

    // Source of the word sent across one direction.
    typedef enum logic {
        SRC_LIVE   = 1'b0,
        SRC_STORED = 1'b1
    } xcvr_src_e;

    // Drive decision for the two bus sides.
    typedef struct packed {
        logic drive_a;
        logic drive_b;
    } xcvr_drive_t;
endpackage

// File: rtl/xcvr_store_reg.sv
// Module: xcvr_store_reg
// Holds one direction's stored word. It loads d on each rising clk edge
// and clears it on an edge where rst_n is low.
// Assumes d is stable around the clk edge.
module xcvr_store_reg #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    // Capture the source bus, with a synchronous clear.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/xcvr_path.sv
// Module: xcvr_path
// Picks the live or the stored word for one direction and applies the
// polarity chosen at build time. Each bit of the mux has a consensus term,
// so the output stays put when live and stored agree while sel changes.
// Assumes sel is a single-bit level (xcvr_src_e encoding).
module xcvr_path #(
    parameter int unsigned W      = 8,
    parameter bit          INVERT = 1'b0
) (
    input  logic         sel,
    input  logic [W-1:0] live,
    input  logic [W-1:0] stored,
    output logic [W-1:0] q
);
    logic [W-1:0] picked;

    // Glitch-free per-bit selection, repeated for every bit.
    for (genvar i = 0; i < W; i++) begin : g_bit
        assign picked[i] = (sel & stored[i]) | (~sel & live[i]) | (stored[i] & live[i]);
    end

    // Polarity stage picked by the build option.
    if (INVERT) begin : g_inv
        assign q = ~picked;
    end else begin : g_true
        assign q = picked;
    end
endmodule

// File: rtl/xcvr_drive_ctrl.sv
// Module: xcvr_drive_ctrl
// Turns the enable and the direction into the two drive flags. At most one
// flag is ever set, and both are clear while rst_n is low.
// Assumes no inputs beyond the three levels listed.
module xcvr_drive_ctrl
    import xcvr_pkg::*;
(
    input  logic        rst_n,
    input  logic        oe_n,
    input  logic        dir,
    output xcvr_drive_t drv
);
    // Decode the driven side; isolation and reset clear both flags.
    always_comb begin
        drv = '0;
        if (rst_n && !oe_n) begin
            if (dir) drv.drive_b = 1'b1;
            else     drv.drive_a = 1'b1;
        end
    end
endmodule

// File: rtl/xcvr_reg_bidir.sv
// Module: xcvr_reg_bidir (top)
// An 8-bit transceiver with a storage register for each direction. Each
// register has its own clock. The word sent in each direction is live or
// stored, and the path can be true or inverting.
// Assumes: inputs are steady around capture edges, and the buses are split
// into input, output and drive flag by the surrounding logic.
module xcvr_reg_bidir
    import xcvr_pkg::*;
#(
    parameter int unsigned W      = XCVR_W,
    parameter bit          INVERT = 1'b0
) (
    input  logic         clk_ab,
    input  logic         clk_ba,
    input  logic         rst_n,
    input  logic         oe_n,
    input  logic         dir,
    input  logic         sel_ab,
    input  logic         sel_ba,
    input  logic [W-1:0] a_in,
    output logic [W-1:0] a_out,
    output logic         a_oe,
    input  logic [W-1:0] b_in,
    output logic [W-1:0] b_out,
    output logic         b_oe
);
    logic [W-1:0] st_a;
    logic [W-1:0] st_b;
    xcvr_drive_t  drv;

    // Stored A word, clocked by the A-to-B clock.
    xcvr_store_reg #(.W(W)) u_reg_a (
        .clk(clk_ab), .rst_n(rst_n), .d(a_in), .q(st_a)
    );

    // Stored B word, clocked by the B-to-A clock.
    xcvr_store_reg #(.W(W)) u_reg_b (
        .clk(clk_ba), .rst_n(rst_n), .d(b_in), .q(st_b)
    );

    // Word offered to bus B.
    xcvr_path #(.W(W), .INVERT(INVERT)) u_path_ab (
        .sel(sel_ab), .live(a_in), .stored(st_a), .q(b_out)
    );

    // Word offered to bus A.
    xcvr_path #(.W(W), .INVERT(INVERT)) u_path_ba (
        .sel(sel_ba), .live(b_in), .stored(st_b), .q(a_out)
    );

    // Decision on which side is driven.
    xcvr_drive_ctrl u_ctrl (
        .rst_n(rst_n), .oe_n(oe_n), .dir(dir), .drv(drv)
    );

    assign a_oe = drv.drive_a;
    assign b_oe = drv.drive_b;
endmodule

// File: rtl/xcvr_reg_bidir_chk.sv
// Module: xcvr_reg_bidir_chk
// Checker bound to the top. Its properties are sampled on both capture clocks.
// Assumes that inputs are steady around the edges.
module xcvr_reg_bidir_chk #(
    parameter int unsigned W      = 8,
    parameter bit          INVERT = 1'b0
) (
    input logic         clk_ab,
    input logic         clk_ba,
    input logic         rst_n,
    input logic         oe_n,
    input logic         dir,
    input logic         sel_ab,
    input logic         sel_ba,
    input logic [W-1:0] a_in,
    input logic [W-1:0] b_in,
    input logic [W-1:0] a_out,
    input logic [W-1:0] b_out,
    input logic         a_oe,
    input logic         b_oe,
    input logic [W-1:0] st_a,
    input logic [W-1:0] st_b
);
    localparam logic [W-1:0] POL = INVERT ? {W{1'b1}} : {W{1'b0}};

    assert_cap_a_R1: assert property (@(posedge clk_ab) disable iff (!rst_n)
        1'b1 |=> st_a == $past(a_in));
    assert_cap_b_R2: assert property (@(posedge clk_ba) disable iff (!rst_n)
        1'b1 |=> st_b == $past(b_in));
    assert_drive_b_R3: assert property (@(posedge clk_ab) disable iff (!rst_n)
        (!oe_n && dir) |-> (b_oe && !a_oe));
    assert_drive_a_R3: assert property (@(posedge clk_ba) disable iff (!rst_n)
        (!oe_n && !dir) |-> (a_oe && !b_oe));
    assert_isolate_R4: assert property (@(posedge clk_ab) disable iff (!rst_n)
        oe_n |-> (!a_oe && !b_oe));
    assert_ab_live_R5: assert property (@(posedge clk_ab) disable iff (!rst_n)
        !sel_ab |-> b_out == (a_in ^ POL));
    assert_ba_live_R6: assert property (@(posedge clk_ba) disable iff (!rst_n)
        !sel_ba |-> a_out == (b_in ^ POL));
    assert_one_side_R7: assert property (@(posedge clk_ab) disable iff (!rst_n)
        $countones({a_oe, b_oe}) <= 1);
    assert_ab_hold_R10: assert property (@(posedge clk_ba) disable iff (!rst_n)
        sel_ab |-> b_out == (st_a ^ POL));
    assert_ba_hold_R10: assert property (@(posedge clk_ab) disable iff (!rst_n)
        sel_ba |-> a_out == (st_b ^ POL));
endmodule

bind xcvr_reg_bidir xcvr_reg_bidir_chk #(.W(W), .INVERT(INVERT)) u_chk (
    .clk_ab(clk_ab), .clk_ba(clk_ba), .rst_n(rst_n), .oe_n(oe_n), .dir(dir),
    .sel_ab(sel_ab), .sel_ba(sel_ba), .a_in(a_in), .b_in(b_in),
    .a_out(a_out), .b_out(b_out), .a_oe(a_oe), .b_oe(b_oe),
    .st_a(st_a), .st_b(st_b)
);

// File: tb/sim_xcvr_reg_bidir.sv
module sim_xcvr_reg_bidir;
    localparam int CLK_PERIOD = 10;

    logic       clk_ab = 0, clk_ba = 0, rst_n = 0, oe_n = 1, dir = 0;
    logic       sel_ab = 0, sel_ba = 0;
    logic [7:0] a_in = 0, b_in = 0;
    logic [7:0] a_out, b_out, ia_out, ib_out;
    logic       a_oe, b_oe, ia_oe, ib_oe;
    logic [7:0] ma, mb;          // model of the stored words
    int         n_chk = 0, n_bad = 0;
    bit         done = 0;

    xcvr_reg_bidir u0 (
        .clk_ab(clk_ab), .clk_ba(clk_ba), .rst_n(rst_n), .oe_n(oe_n), .dir(dir),
        .sel_ab(sel_ab), .sel_ba(sel_ba), .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
        .b_in(b_in), .b_out(b_out), .b_oe(b_oe)
    );
    xcvr_reg_bidir #(.INVERT(1'b1)) u1 (
        .clk_ab(clk_ab), .clk_ba(clk_ba), .rst_n(rst_n), .oe_n(oe_n), .dir(dir),
        .sel_ab(sel_ab), .sel_ba(sel_ba), .a_in(a_in), .a_out(ia_out), .a_oe(ia_oe),
        .b_in(b_in), .b_out(ib_out), .b_oe(ib_oe)
    );

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] exp_b_word();
        return sel_ab ? ma : a_in;
    endfunction
    function automatic logic [7:0] exp_a_word();
        return sel_ba ? mb : b_in;
    endfunction

    // Compare every output of both builds with the model.
    task automatic check_all();
        logic eb, ea;
        #1;
        eb = rst_n & ~oe_n & dir;
        ea = rst_n & ~oe_n & ~dir;
        chk("R5 b_out", b_out, exp_b_word());
        chk("R6 a_out", a_out, exp_a_word());
        chk("R3/R4 b_oe", {7'd0, b_oe}, {7'd0, eb});
        chk("R3/R4 a_oe", {7'd0, a_oe}, {7'd0, ea});
        chk("R7 one side", {7'd0, a_oe & b_oe}, 8'd0);
        chk("R8 inverted b_out", ib_out, ~exp_b_word());
        chk("R8 inverted a_out", ia_out, ~exp_a_word());
        chk("R8 inverted flags", {6'd0, ia_oe, ib_oe}, {6'd0, ea, eb});
    endtask

    task automatic pulse_ab();
        #(CLK_PERIOD/2) clk_ab = 1;
        ma = rst_n ? a_in : 8'h00;
        #(CLK_PERIOD/2) clk_ab = 0;
    endtask
    task automatic pulse_ba();
        #(CLK_PERIOD/2) clk_ba = 1;
        mb = rst_n ? b_in : 8'h00;
        #(CLK_PERIOD/2) clk_ba = 0;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        ma = 8'hxx; mb = 8'hxx;
        // R9: reset clears registers; flags low during reset
        a_in = 8'hC3; b_in = 8'h3C; oe_n = 0; dir = 1;
        pulse_ab(); pulse_ba();
        sel_ab = 1; sel_ba = 1;
        #1;
        chk("R9 reset A reg", b_out, 8'h00);
        chk("R9 reset B reg", a_out, 8'h00);
        chk("R9 flags in reset", {6'd0, a_oe, b_oe}, 8'd0);
        rst_n = 1;
        check_all();

        // R4: capture while isolated, then view it
        oe_n = 1; a_in = 8'h5A; b_in = 8'hA5;
        check_all();
        pulse_ab(); pulse_ba();
        a_in = 8'h00; b_in = 8'h00; oe_n = 0; dir = 1;
        #1;
        chk("R4 capture A while isolated", b_out, 8'h5A);
        chk("R4 capture B while isolated", a_out, 8'hA5);

        // R1/R2: each clock touches only its own register
        a_in = 8'h11; b_in = 8'h22;
        pulse_ba();
        #1 chk("R1 A reg unchanged by clk_ba", b_out, 8'h5A);
        pulse_ab();
        #1 chk("R2 B reg unchanged by clk_ab", a_out, 8'h22);
        chk("R1 A reg captured", b_out, 8'h11);

        // R10: stored path holds while the live input moves
        a_in = 8'hFF; b_in = 8'h80;
        #1 chk("R10 A stored hold", b_out, 8'h11);
        chk("R10 B stored hold", a_out, 8'h22);

        // R11: equal live and stored, toggle the select
        a_in = 8'h11; sel_ab = 0;
        #1 chk("R11 toggle to live", b_out, 8'h11);
        sel_ab = 1;
        #1 chk("R11 toggle to stored", b_out, 8'h11);

        // R3/R5/R6: every control combination, then random mix
        for (int c = 0; c < 16; c++) begin
            {oe_n, dir, sel_ab, sel_ba} = c[3:0];
            a_in = $urandom; b_in = $urandom;
            check_all();
        end
        void'($urandom(32'h1A2B));
        for (int k = 0; k < 400; k++) begin
            int r;
            r = $urandom % 8;
            {oe_n, dir, sel_ab, sel_ba} = $urandom;
            a_in = $urandom; b_in = $urandom;
            rst_n = (r != 0) || (k < 20);
            if (r < 4) pulse_ab();
            else if (r < 7) pulse_ba();
            check_all();
            a_in = $urandom;
            b_in = $urandom;
            check_all();
        end
        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule